// File: doc/BRIEF.md
# I/O Channel Program Sequencer

This block is a single-channel I/O processor. The host hands it a start command naming a device and the memory address of a command chain. From then on the sequencer works alone: it fetches each 64-bit command word over the shared memory bus, decodes it and acts on it. It can move a block of words between the device and memory, forward a device-control code to the device and wait for the device's handshake, or redirect fetching to another address. After each command the control flags decide whether the chain goes on. When the chain ends, the host gets a one-cycle interrupt and a status word.

Every memory access is an arbitrated bus cycle. The sequencer raises `bus_req` and uses the bus only in a cycle where `bus_gnt` is also high. The memory answers reads in the same cycle (`mem_rdata` is valid while `mem_en` is high) and takes writes at the clock edge. Device data ports are always ready. One word moves per granted cycle, and `dev_rd` or `dev_wr` marks the device side of that word.

States: IDLE (waiting for a start), FETCH_A (reads the head word at the fetch address), FETCH_B (reads the address word at fetch address + 4), DECODE (classifies the opcode and sets the next fetch address), MOVE (one word per granted cycle), DEVCTL (device-control handshake), NEXT (applies the end and chain flags) and FINISH (interrupt cycle). Transitions:
- IDLE→FETCH_A on a valid start.
- FETCH_A→FETCH_B and FETCH_B→DECODE on a grant.
- DECODE→MOVE for a transfer with a nonzero count.
- DECODE→NEXT for a zero-count transfer or a branch.
- DECODE→DEVCTL for a control command.
- DECODE→FINISH for an unknown opcode.
- MOVE→NEXT on the granted cycle of the last word.
- DEVCTL→NEXT on `dev_ctl_done`.
- NEXT→FETCH_A when the chain flag is set and the end flag is clear.
- NEXT→FINISH otherwise.
- FINISH→IDLE always.

Top module: `chan_seq`

## Requirements
- R1: A start is accepted only in IDLE and only when `start_cmd[47:40]` equals START_OP (default 0xA5). The device address is in bits [39:32] and the chain address is in bits [31:0]. Any other start has no effect: no bus request, no interrupt and `busy` stays low. `busy` is high from the cycle after acceptance until the program finishes.
- R2: Each command is fetched as two bus reads. The first read is at fetch address P and gives the head word: opcode [31:24], flags [23:16], count [15:0]. The second read is at P+4 and gives the 32-bit address field. `mem_en` is only ever high together with both `bus_req` and `bus_gnt`.
- R3: Opcode 0x01 moves `count` words from the device into memory at addr, addr+4, and so on. Each word is one granted write cycle, with `dev_rd` high in that cycle.
- R4: Opcode 0x02 moves `count` words from memory at addr, addr+4, and so on to the device. Each word is one granted read cycle, with `dev_wr` high and `dev_wdata` carrying the word.
- R5: A transfer command with count 0 makes no memory access beyond its two fetch reads and goes straight to flag handling.
- R6: Opcodes 0x40 to 0x7F are device-control commands. The sequencer holds `dev_ctl_valid` high and `dev_ctl_op` steady until `dev_ctl_done`. It makes no memory access for them, and the next fetch starts only after the handshake.
- R7: Opcode 0x08 is a branch. The next command is fetched from its address field instead of from P+8.
- R8: After a command, flag bit 1 (end) finishes the program and takes priority over flag bit 0 (chain). With chain set and end clear, the next command is fetched (from P+8 unless the command was a branch). With both flags clear, the program finishes with the end bit in status clear.
- R9: Any other opcode finishes the program at once, without further bus or device activity, and sets the error bit in status.
- R10: On finishing, `irq` is high for exactly one cycle. The status word is valid in that same cycle and is held until the next program finishes. Its layout is: [31:24] last opcode, [23:16] device, [15:8] last flags, [7:2] zero, [1] error, [0] end flag seen. Status is zero after reset.
- R11: `dev_sel` presents the accepted device address and stays stable while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start command strobe |
| start_cmd | input | 48 | Start opcode, device address, chain address |
| busy | output | 1 | A program is running |
| irq | output | 1 | One-cycle completion interrupt |
| status | output | 32 | Completion status word |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_en | output | 1 | Memory access in this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, same cycle |
| dev_sel | output | 8 | Selected device address |
| dev_rd | output | 1 | Device word consumed |
| dev_rdata | input | 32 | Device data toward memory |
| dev_wr | output | 1 | Device word delivered |
| dev_wdata | output | 32 | Data toward device |
| dev_ctl_valid | output | 1 | Device-control command pending |
| dev_ctl_op | output | 8 | Device-control opcode |
| dev_ctl_done | input | 1 | Device-control handshake |

## Verification
The bench builds the block with its default parameters: AW=32, CW=16 and START_OP=0xA5. It attaches a 64-word memory model decoded on address bits [7:2], so command chains, branch targets and data areas all fit in one small address map.

The bench sweeps both transfer directions over counts 0 to 5 under three grant patterns: every cycle, every second cycle and every third cycle. This covers the zero-count path, the last-word exit from MOVE and how the block behaves while it waits for a grant.

Directed chains cover the remaining paths: control handshakes, a branch that skips a poisoned word, end-over-chain priority, a chain that stops with both flags clear, an unknown opcode, and starts that must be ignored.

// File: rtl/chan_pkg.sv
package chan_pkg;

    typedef enum logic [2:0] {
        IDLE,
        FETCH_A,
        FETCH_B,
        DECODE,
        MOVE,
        DEVCTL,
        NEXT,
        FINISH
    } seq_state_t;

    typedef enum logic [2:0] {
        K_IN,
        K_OUT,
        K_JUMP,
        K_CTL,
        K_BAD
    } cmd_kind_t;

    localparam logic [7:0] OP_DEV_TO_MEM = 8'h01;
    localparam logic [7:0] OP_MEM_TO_DEV = 8'h02;
    localparam logic [7:0] OP_JUMP       = 8'h08;

    localparam int FLAG_CHAIN_BIT = 0;
    localparam int FLAG_END_BIT   = 1;

    function automatic cmd_kind_t classify(input logic [7:0] op);
        cmd_kind_t k;
        if (op == OP_DEV_TO_MEM)      k = K_IN;
        else if (op == OP_MEM_TO_DEV) k = K_OUT;
        else if (op == OP_JUMP)       k = K_JUMP;
        else if (op[7:6] == 2'b01)    k = K_CTL;
        else                          k = K_BAD;
        return k;
    endfunction

endpackage

// File: rtl/chan_cmd_reg.sv
module chan_cmd_reg
    import chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_head,
    input  logic          load_tail,
    input  logic [31:0]   word_in,
    output logic [7:0]    op,
    output logic [7:0]    flags,
    output logic [CW-1:0] count,
    output logic [AW-1:0] target,
    output cmd_kind_t     kind
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op     <= '0;
            flags  <= '0;
            count  <= '0;
            target <= '0;
        end else begin
            if (load_head) begin
                op    <= word_in[31:24];
                flags <= word_in[23:16];
                count <= word_in[CW-1:0];
            end
            if (load_tail) begin
                target <= word_in[AW-1:0];
            end
        end
    end

    always_comb kind = classify(op);

endmodule

// File: rtl/chan_xfer_engine.sv
module chan_xfer_engine #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] remain,
    output logic          last
);

    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= load_addr;
            remain <= load_cnt;
        end else if (step) begin
            addr   <= addr + WORD_BYTES;
            remain <= remain - CW'(1);
        end
    end

    always_comb last = (remain == CW'(1));

    // R5: a step is never taken with nothing left to move
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remain != '0));

endmodule

// File: rtl/chan_ctrl_fsm.sv
module chan_ctrl_fsm
    import chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_hit,
    input  cmd_kind_t  kind,
    input  logic       flag_chain,
    input  logic       flag_end,
    input  logic       cmd_empty,
    input  logic       move_last,
    input  logic       bus_gnt,
    input  logic       ctl_done,
    output seq_state_t state,
    output logic       busy,
    output logic       bus_req,
    output logic       grant_use,
    output logic       load_head,
    output logic       load_tail,
    output logic       eng_load,
    output logic       eng_step,
    output logic       ctl_valid,
    output logic       pc_start,
    output logic       pc_update,
    output logic       close,
    output logic       close_err,
    output logic       close_eop,
    output logic       irq
);

    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:    if (start_hit) state_d = FETCH_A;
            FETCH_A: if (bus_gnt)   state_d = FETCH_B;
            FETCH_B: if (bus_gnt)   state_d = DECODE;
            DECODE: begin
                unique case (kind)
                    K_IN, K_OUT: state_d = cmd_empty ? NEXT : MOVE;
                    K_JUMP:      state_d = NEXT;
                    K_CTL:       state_d = DEVCTL;
                    K_BAD:       state_d = FINISH;
                    default:     state_d = FINISH;
                endcase
            end
            MOVE:    if (bus_gnt && move_last) state_d = NEXT;
            DEVCTL:  if (ctl_done) state_d = NEXT;
            NEXT:    state_d = (flag_chain && !flag_end) ? FETCH_A : FINISH;
            FINISH:  state_d = IDLE;
            default: state_d = IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != IDLE);
        bus_req   = (state_q == FETCH_A) || (state_q == FETCH_B) || (state_q == MOVE);
        grant_use = bus_req && bus_gnt;
        load_head = (state_q == FETCH_A) && bus_gnt;
        load_tail = (state_q == FETCH_B) && bus_gnt;
        eng_load  = (state_q == DECODE);
        eng_step  = (state_q == MOVE) && bus_gnt;
        ctl_valid = (state_q == DEVCTL);
        pc_start  = (state_q == IDLE) && start_hit;
        pc_update = (state_q == DECODE);
        close_err = (state_q == DECODE) && (kind == K_BAD);
        close_eop = (state_q == NEXT) && flag_end;
        close     = close_err || ((state_q == NEXT) && (flag_end || !flag_chain));
        irq       = (state_q == FINISH);
    end

    always_comb state = state_q;

    // R10: the interrupt never lasts two cycles
    a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: a pending control command stays up until the device answers
    a_r6_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && !ctl_done) |=> ctl_valid);

endmodule

// File: rtl/chan_seq.sv
module chan_seq
    import chan_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          CW       = 16,
    parameter logic [7:0]  START_OP = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    input  logic [47:0]   start_cmd,
    output logic          busy,
    output logic          irq,
    output logic [31:0]   status,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic [7:0]    dev_sel,
    output logic          dev_rd,
    input  logic [31:0]   dev_rdata,
    output logic          dev_wr,
    output logic [31:0]   dev_wdata,
    output logic          dev_ctl_valid,
    output logic [7:0]    dev_ctl_op,
    input  logic          dev_ctl_done
);

    localparam logic [AW-1:0] TAIL_OFS = AW'(4);
    localparam logic [AW-1:0] CMD_SIZE = AW'(8);

    seq_state_t    state;
    cmd_kind_t     kind;
    logic          start_hit;
    logic          grant_use, load_head, load_tail, eng_load, eng_step;
    logic          pc_start, pc_update, close, close_err, close_eop;
    logic [7:0]    cmd_op, cmd_flags;
    logic [CW-1:0] cmd_count, eng_remain;
    logic [AW-1:0] cmd_target, eng_addr;
    logic          eng_last;
    logic [AW-1:0] pc_q;
    logic [7:0]    dev_q;
    logic [31:0]   status_q;

    always_comb start_hit = start_valid && (start_cmd[47:40] == START_OP);

    chan_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_hit  (start_hit),
        .kind       (kind),
        .flag_chain (cmd_flags[FLAG_CHAIN_BIT]),
        .flag_end   (cmd_flags[FLAG_END_BIT]),
        .cmd_empty  (cmd_count == '0),
        .move_last  (eng_last),
        .bus_gnt    (bus_gnt),
        .ctl_done   (dev_ctl_done),
        .state      (state),
        .busy       (busy),
        .bus_req    (bus_req),
        .grant_use  (grant_use),
        .load_head  (load_head),
        .load_tail  (load_tail),
        .eng_load   (eng_load),
        .eng_step   (eng_step),
        .ctl_valid  (dev_ctl_valid),
        .pc_start   (pc_start),
        .pc_update  (pc_update),
        .close      (close),
        .close_err  (close_err),
        .close_eop  (close_eop),
        .irq        (irq)
    );

    chan_cmd_reg #(.AW(AW), .CW(CW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_head (load_head),
        .load_tail (load_tail),
        .word_in   (mem_rdata),
        .op        (cmd_op),
        .flags     (cmd_flags),
        .count     (cmd_count),
        .target    (cmd_target),
        .kind      (kind)
    );

    chan_xfer_engine #(.AW(AW), .CW(CW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (eng_load),
        .load_addr (cmd_target),
        .load_cnt  (cmd_count),
        .step      (eng_step),
        .addr      (eng_addr),
        .remain    (eng_remain),
        .last      (eng_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= '0;
            dev_q    <= '0;
            status_q <= '0;
        end else begin
            if (pc_start) begin
                pc_q  <= start_cmd[AW-1:0];
                dev_q <= start_cmd[39:32];
            end else if (pc_update) begin
                pc_q <= (kind == K_JUMP) ? cmd_target : (pc_q + CMD_SIZE);
            end
            if (close) begin
                status_q <= {cmd_op, dev_q, cmd_flags, 6'b0, close_err, close_eop};
            end
        end
    end

    always_comb begin
        mem_en    = grant_use;
        mem_we    = (state == MOVE) && (kind == K_IN);
        mem_wdata = dev_rdata;
        unique case (state)
            FETCH_A: mem_addr = pc_q;
            FETCH_B: mem_addr = pc_q + TAIL_OFS;
            MOVE:    mem_addr = eng_addr;
            default: mem_addr = pc_q;
        endcase
        dev_rd     = grant_use && (state == MOVE) && (kind == K_IN);
        dev_wr     = grant_use && (state == MOVE) && (kind == K_OUT);
        dev_wdata  = mem_rdata;
        dev_ctl_op = cmd_op;
        dev_sel    = dev_q;
        status     = status_q;
    end

    // R2: no bus cycle without a request that has been granted
    a_r2_access_granted: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (bus_req && bus_gnt));

    // R3: a device read is always paired with a memory write
    a_r3_rd_pairs_write: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |-> (mem_en && mem_we));

    // R4: a device write is always paired with a memory read
    a_r4_wr_pairs_read: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> (mem_en && !mem_we));

    // R6: the forwarded code does not change while the device is still working
    a_r6_op_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ctl_valid && !dev_ctl_done) |=> $stable(dev_ctl_op));

    // R6: a control command never touches memory
    a_r6_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ctl_valid |-> !mem_en);

    // R1: an accepted start makes the block busy on the next cycle
    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_valid && (start_cmd[47:40] == START_OP)) |=> busy);

    // R9: error and end-of-program are never reported together
    a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !(status[1] && status[0]));

    // R11: the selected device holds while a program runs
    a_r11_dev_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(dev_sel)));

endmodule

// File: tb/chan_seq_bench.sv
module chan_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [47:0] start_cmd = '0;
    logic        busy, irq, bus_req, mem_en, mem_we, dev_rd, dev_wr, dev_ctl_valid;
    logic        bus_gnt = 1'b0;
    logic        dev_ctl_done = 1'b0;
    logic [31:0] status, mem_addr, mem_wdata, mem_rdata, dev_wdata, dev_rdata;
    logic [7:0]  dev_sel, dev_ctl_op;

    always #5 clk = ~clk;

    chan_seq u_chan_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_valid   (start_valid),
        .start_cmd     (start_cmd),
        .busy          (busy),
        .irq           (irq),
        .status        (status),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .mem_en        (mem_en),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .dev_sel       (dev_sel),
        .dev_rd        (dev_rd),
        .dev_rdata     (dev_rdata),
        .dev_wr        (dev_wr),
        .dev_wdata     (dev_wdata),
        .dev_ctl_valid (dev_ctl_valid),
        .dev_ctl_op    (dev_ctl_op),
        .dev_ctl_done  (dev_ctl_done)
    );

    // memory model with a host poke port
    logic [31:0] mem [0:63];
    logic        hw_en = 1'b0;
    logic [5:0]  hw_idx = '0;
    logic [31:0] hw_data = '0;
    assign mem_rdata = mem[mem_addr[7:2]];
    always @(posedge clk) begin
        if (hw_en) mem[hw_idx] <= hw_data;
        else if (mem_en && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end

    // grant pattern
    int gmode = 0;
    int gcyc = 0;
    always @(negedge clk) begin
        gcyc    <= gcyc + 1;
        bus_gnt <= (gmode == 0) ? 1'b1 : ((gcyc % (gmode + 1)) == 0);
    end

    // control handshake: done after three waiting cycles
    int ctl_wait = 0;
    always @(negedge clk) begin
        dev_ctl_done <= 1'b0;
        if (dev_ctl_valid && !dev_ctl_done) begin
            if (ctl_wait == 2) begin
                dev_ctl_done <= 1'b1;
                ctl_wait     <= 0;
            end else begin
                ctl_wait <= ctl_wait + 1;
            end
        end
    end

    // observation counters
    logic        clr = 1'b0;
    int          n_acc = 0, n_rd = 0, n_wr = 0, n_ctl = 0, irq_cnt = 0;
    logic [31:0] out_log [0:15];
    logic [7:0]  ctl_log [0:7];
    logic [7:0]  ctl_dev = '0;
    logic [31:0] last_status = '0;
    assign dev_rdata = 32'hD000_0000 + 32'(n_rd);

    always @(posedge clk) begin
        if (irq) begin
            irq_cnt     <= irq_cnt + 1;
            last_status <= status;
        end
        if (clr) begin
            n_acc <= 0; n_rd <= 0; n_wr <= 0; n_ctl <= 0;
        end else begin
            if (mem_en) n_acc <= n_acc + 1;
            if (dev_rd) n_rd <= n_rd + 1;
            if (dev_wr) begin
                out_log[n_wr % 16] <= dev_wdata;
                n_wr <= n_wr + 1;
            end
            if (dev_ctl_valid && dev_ctl_done) begin
                ctl_log[n_ctl % 8] <= dev_ctl_op;
                ctl_dev <= dev_sel;
                n_ctl   <= n_ctl + 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    logic timed_out = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_idx = 6'(idx); hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic put_cmd(input int byte_addr, input logic [7:0] op, input logic [7:0] fl,
                           input logic [15:0] cnt, input logic [31:0] tgt);
        poke(byte_addr / 4, {op, fl, cnt});
        poke(byte_addr / 4 + 1, tgt);
    endtask

    task automatic clear_obs();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic run(input logic [31:0] prog, input logic [7:0] dev);
        int base;
        int waited;
        base = irq_cnt;
        @(negedge clk);
        start_valid = 1'b1; start_cmd = {8'hA5, dev, prog};
        @(negedge clk);
        start_valid = 1'b0;
        waited = 0;
        while (irq_cnt == base && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check("R10 completion seen", 32'(irq_cnt - base), 32'd1);
        @(negedge clk);
    endtask

    function automatic logic [31:0] stat(input logic [7:0] op, input logic [7:0] dev,
                                         input logic [7:0] fl, input logic err, input logic eop);
        return {op, dev, fl, 6'b0, err, eop};
    endfunction

    initial begin
        fork
            begin : tests
                int base;
                repeat (3) @(negedge clk);
                // reset state (R1, R10)
                check("R1 busy after reset", {31'b0, busy}, 32'd0);
                check("R10 irq after reset", {31'b0, irq}, 32'd0);
                check("R10 status after reset", status, 32'd0);
                check("R2 bus_req after reset", {31'b0, bus_req}, 32'd0);
                rst_n = 1'b1;
                @(negedge clk);

                // R1: wrong start opcode is ignored
                put_cmd(0, 8'h44, 8'h02, 16'd0, 32'd0);
                clear_obs();
                base = irq_cnt;
                start_valid = 1'b1; start_cmd = {8'h5A, 8'h11, 32'd0};
                @(negedge clk);
                start_valid = 1'b0;
                repeat (20) @(negedge clk);
                check("R1 bad start busy", {31'b0, busy}, 32'd0);
                check("R1 bad start no irq", 32'(irq_cnt - base), 32'd0);
                check("R1 bad start no access", 32'(n_acc), 32'd0);

                // R2..R5: sweep direction, count and grant pattern
                for (int g = 0; g < 3; g++) begin
                    gmode = g;
                    for (int dir = 0; dir < 2; dir++) begin
                        for (int n = 0; n < 6; n++) begin
                            logic [7:0] op;
                            op = (dir == 0) ? 8'h01 : 8'h02;
                            for (int i = 0; i < 8; i++)
                                poke(16 + i, 32'hA000_0000 + 32'(g * 256 + n * 16 + i));
                            put_cmd(0, op, 8'h02, 16'(n), 32'h40);
                            clear_obs();
                            run(32'h0, 8'h30 + 8'(n));
                            check("R2 R5 access count", 32'(n_acc), 32'(2 + n));
                            check("R10 status", last_status, stat(op, 8'h30 + 8'(n), 8'h02, 1'b0, 1'b1));
                            if (dir == 0) begin
                                check("R3 dev reads", 32'(n_rd), 32'(n));
                                for (int i = 0; i < n; i++)
                                    check("R3 stored word", mem[16 + i], 32'hD000_0000 + 32'(i));
                                check("R3 word past end untouched", mem[16 + n],
                                      32'hA000_0000 + 32'(g * 256 + n * 16 + n));
                            end else begin
                                check("R4 dev writes", 32'(n_wr), 32'(n));
                                for (int i = 0; i < n; i++)
                                    check("R4 delivered word", out_log[i],
                                          32'hA000_0000 + 32'(g * 256 + n * 16 + i));
                            end
                        end
                    end
                end

                // R6, R7, R8: control, branch, transfer, end-over-chain
                gmode = 1;
                poke(48, 32'h1234_5678);
                poke(49, 32'h9ABC_DEF0);
                put_cmd(8'h00, 8'h47, 8'h01, 16'd0, 32'h0);
                put_cmd(8'h08, 8'h08, 8'h01, 16'd0, 32'hA0);
                put_cmd(8'h10, 8'hFF, 8'h01, 16'd0, 32'h0);
                put_cmd(8'hA0, 8'h02, 8'h01, 16'd2, 32'hC0);
                put_cmd(8'hA8, 8'h5C, 8'h03, 16'd0, 32'h0);
                put_cmd(8'hB0, 8'h61, 8'h02, 16'd0, 32'h0);
                clear_obs();
                run(32'h0, 8'h5A);
                check("R6 control count", 32'(n_ctl), 32'd2);
                check("R6 first control op", {24'b0, ctl_log[0]}, 32'h47);
                check("R6 second control op", {24'b0, ctl_log[1]}, 32'h5C);
                check("R11 device at handshake", {24'b0, ctl_dev}, 32'h5A);
                check("R7 words after branch", 32'(n_wr), 32'd2);
                check("R7 branch data 0", out_log[0], 32'h1234_5678);
                check("R7 branch data 1", out_log[1], 32'h9ABC_DEF0);
                check("R7 R8 access count", 32'(n_acc), 32'd10);
                check("R8 end over chain status", last_status, stat(8'h5C, 8'h5A, 8'h03, 1'b0, 1'b1));

                // R8: both flags clear ends the chain; R1: start while busy ignored
                gmode = 0;
                put_cmd(8'h00, 8'h42, 8'h00, 16'd0, 32'h0);
                put_cmd(8'h08, 8'h43, 8'h02, 16'd0, 32'h0);
                clear_obs();
                base = irq_cnt;
                @(negedge clk);
                start_valid = 1'b1; start_cmd = {8'hA5, 8'h21, 32'h0};
                @(negedge clk);
                start_valid = 1'b0;
                @(negedge clk);
                start_valid = 1'b1; start_cmd = {8'hA5, 8'h22, 32'h8};
                @(negedge clk);
                start_valid = 1'b0;
                repeat (40) @(negedge clk);
                check("R1 start while busy ignored", 32'(irq_cnt - base), 32'd1);
                check("R8 chain stop controls", 32'(n_ctl), 32'd1);
                check("R8 chain stop status", last_status, stat(8'h42, 8'h21, 8'h00, 1'b0, 1'b0));
                check("R10 status held", status, stat(8'h42, 8'h21, 8'h00, 1'b0, 1'b0));

                // R9: unknown opcode ends with error
                put_cmd(8'h00, 8'h44, 8'h01, 16'd0, 32'h0);
                put_cmd(8'h08, 8'h20, 8'h01, 16'd3, 32'h40);
                put_cmd(8'h10, 8'h45, 8'h02, 16'd0, 32'h0);
                clear_obs();
                run(32'h0, 8'h77);
                check("R9 error status", last_status, stat(8'h20, 8'h77, 8'h01, 1'b1, 1'b0));
                check("R9 access count", 32'(n_acc), 32'd4);
                check("R9 no device data", 32'(n_rd + n_wr), 32'd0);
                check("R9 controls before error", 32'(n_ctl), 32'd1);
                check("R1 idle after end", {31'b0, busy}, 32'd0);
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule